// File: doc/BRIEF.md
# Four-Operation Accumulator Core

This block is a minimal processor built around one 16-bit accumulator. Every instruction is 13 bits wide and names one operand. The core reads the instruction addressed by its program counter from an external instruction memory. It takes the operand from one of eight internal general registers or from an external 1024-word data memory. It then replaces the accumulator with the sum, difference, product or quotient of the accumulator and that operand. There are no stores, jumps, interrupts or I/O, so the program runs straight through memory and the program counter wraps at the end.

Both memories are synchronous: data appears one cycle after the address. The general registers have no reset. They are loaded through a write port, which may be used at any time, including while the core is held in reset, and any one of them can be read back through an observation port. Two sticky flags report a zero divisor and a malformed register-mode instruction. Neither flag stops execution.

Top module: `acc4_core`

## Requirements
- R1: An instruction word holds the operation code in bits 12:11, the addressing mode in bit 10 and the operand field in bits 9:0.
- R2: Operation code 00 sets the accumulator to the accumulator plus the operand, modulo 2^16.
- R3: Operation code 01 sets the accumulator to the accumulator minus the operand, modulo 2^16.
- R4: Operation code 10 sets the accumulator to the low 16 bits of the unsigned product of the accumulator and the operand.
- R5: Operation code 11 sets the accumulator to the unsigned quotient of the accumulator divided by the operand, with the remainder discarded.
- R6: A divide by a zero operand leaves the accumulator unchanged and sets `div0_err`, which stays set until reset.
- R7: Mode 0 is register mode. Operand field bits 2:0 select general register R0 to R7 by their binary value, and the register's contents are the operand.
- R8: Mode 1 is direct mode. The 10-bit operand field is driven on `dmem_addr` during the second cycle of the instruction, and the data word returned is the operand.
- R9: In register mode, any nonzero bit in operand field bits 9:3 makes the instruction a no-op on the accumulator and sets `illegal_err`, which stays set until reset.
- R10: Each instruction takes exactly three cycles. `imem_addr` shows the program counter, which advances by one at the end of the third cycle. The accumulator changes only at that same edge.
- R11: Reset clears the program counter, the accumulator and both flags.
- R12: A register written through the preload port is visible on the observation port, and its contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 10 | Program counter, used as the instruction memory address |
| imem_data | input | 13 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 10 | Data memory read address |
| dmem_rdata | input | 16 | Data memory word, valid one cycle after the address |
| rf_wr_en | input | 1 | Preload write enable for the general registers |
| rf_wr_idx | input | 3 | Index of the register to preload |
| rf_wr_data | input | 16 | Value to preload |
| rf_rd_idx | input | 3 | Index of the register to observe |
| rf_rd_data | output | 16 | Contents of the observed register (combinational) |
| acc | output | 16 | Accumulator |
| div0_err | output | 1 | Sticky flag for a zero divisor |
| illegal_err | output | 1 | Sticky flag for a malformed register-mode instruction |

## Verification
Each instruction's result is due three rising edges after its program counter value first appears: one edge for the instruction fetch, one for the operand read and one for execution. The accumulator, both flags and the advanced `imem_addr` are therefore sampled at the falling edge that follows the third edge. For direct-mode instructions, `dmem_addr` is sampled at the falling edge after the first edge, while the operand read is in progress. The observation port and the reset values are combinational or held, so they are sampled at a falling edge once the inputs have settled.

// File: rtl/acc4_core.sv
module acc4_core #(
  parameter int DW   = 16,
  parameter int OPW  = 10,
  parameter int NREG = 8,
  parameter int PCW  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [PCW-1:0]          imem_addr,
  input  logic [OPW+2:0]          imem_data,
  output logic [OPW-1:0]          dmem_addr,
  input  logic [DW-1:0]           dmem_rdata,
  input  logic                    rf_wr_en,
  input  logic [$clog2(NREG)-1:0] rf_wr_idx,
  input  logic [DW-1:0]           rf_wr_data,
  input  logic [$clog2(NREG)-1:0] rf_rd_idx,
  output logic [DW-1:0]           rf_rd_data,
  output logic [DW-1:0]           acc,
  output logic                    div0_err,
  output logic                    illegal_err
);
  localparam int IW  = OPW + 3;
  localparam int RIW = $clog2(NREG);

  typedef enum logic [1:0] {ST_FETCH, ST_READ, ST_EXEC} phase_t;

  phase_t          phase;
  logic [PCW-1:0]  pc;
  logic [IW-1:0]   ir;
  logic [DW-1:0]   reg_opnd;
  logic [DW-1:0]   regs [NREG];

  always_ff @(posedge clk)
    if (rf_wr_en) regs[rf_wr_idx] <= rf_wr_data;

  assign rf_rd_data = regs[rf_rd_idx];
  assign imem_addr  = pc;
  assign dmem_addr  = imem_data[OPW-1:0];

  logic [1:0]     opc;
  logic           direct;
  logic [OPW-1:0] field;
  logic [DW-1:0]  src, sum, dif, mul_lo, quo, result;
  logic           malformed, zero_div;

  assign opc       = ir[IW-1:IW-2];
  assign direct    = ir[IW-3];
  assign field     = ir[OPW-1:0];
  assign src       = direct ? dmem_rdata : reg_opnd;
  assign malformed = !direct && (field[OPW-1:RIW] != '0);
  assign zero_div  = (opc == 2'b11) && (src == '0);
  assign sum       = acc + src;
  assign dif       = acc - src;
  assign mul_lo    = acc * src;
  assign quo       = (src == '0) ? acc : acc / src;

  always_comb begin
    case (opc)
      2'b00:   result = sum;
      2'b01:   result = dif;
      2'b10:   result = mul_lo;
      default: result = quo;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= ST_FETCH;
      pc          <= '0;
      ir          <= '0;
      reg_opnd    <= '0;
      acc         <= '0;
      div0_err    <= 1'b0;
      illegal_err <= 1'b0;
    end else begin
      case (phase)
        ST_FETCH: phase <= ST_READ;
        ST_READ: begin
          ir       <= imem_data;
          reg_opnd <= regs[imem_data[RIW-1:0]];
          phase    <= ST_EXEC;
        end
        default: begin
          if (malformed)     illegal_err <= 1'b1;
          else if (zero_div) div0_err    <= 1'b1;
          else               acc         <= result;
          pc    <= pc + PCW'(1);
          phase <= ST_FETCH;
        end
      endcase
    end
  end
endmodule

module acc4_core_chk #(
  parameter int DW  = 16,
  parameter int PCW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PCW-1:0] imem_addr,
  input logic [DW-1:0]  acc,
  input logic           div0_err,
  input logic           illegal_err
);
  logic [1:0] ph;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= '0;
    else        ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd0) |-> $stable(imem_addr));
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_addr != $past(imem_addr)) |-> (imem_addr == $past(imem_addr) + PCW'(1)));
  a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd0) |-> $stable(acc));
  a_r6_div0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div0_err |=> div0_err);
  a_r9_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |=> illegal_err);
endmodule

bind acc4_core acc4_core_chk #(.DW(DW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .acc(acc),
  .div0_err(div0_err), .illegal_err(illegal_err)
);

// File: tb/sim_acc4_core.sv
module sim_acc4_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  imem_addr, dmem_addr;
  logic [12:0] imem_q;
  logic [15:0] dmem_q, rf_wr_data, rf_rd_data, acc;
  logic        rf_wr_en = 1'b0;
  logic [2:0]  rf_wr_idx = '0, rf_rd_idx = '0;
  logic        div0_err, illegal_err;
  logic [12:0] imem [1024];
  logic [15:0] dmem [1024];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc4_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_q),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_q), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .acc(acc), .div0_err(div0_err),
    .illegal_err(illegal_err)
  );

  always_ff @(posedge clk) begin
    imem_q <= imem[imem_addr];
    dmem_q <= dmem[dmem_addr];
  end

  // {instruction, expected acc, expected div0_err, expected illegal_err}
  localparam logic [30:0] VEC [15] = '{
    {13'h0005, 16'h0064, 1'b0, 1'b0},  // R2 R7 ADD R5
    {13'h0405, 16'h006E, 1'b0, 1'b0},  // R2 R8 ADD M[5]
    {13'h0802, 16'h0067, 1'b0, 1'b0},  // R3 SUB R2
    {13'h1001, 16'h0135, 1'b0, 1'b0},  // R4 MULT R1
    {13'h1FFF, 16'h009A, 1'b0, 1'b0},  // R5 R8 DIV M[1023]
    {13'h0805, 16'h0036, 1'b0, 1'b0},  // R3
    {13'h0805, 16'hFFD2, 1'b0, 1'b0},  // R3 wraps below zero
    {13'h1002, 16'hFEBE, 1'b0, 1'b0},  // R4 product truncated
    {13'h0001, 16'hFEC1, 1'b0, 1'b0},  // R2
    {13'h1801, 16'h54EB, 1'b0, 1'b0},  // R5 exact
    {13'h1802, 16'h0C21, 1'b0, 1'b0},  // R5 remainder dropped
    {13'h0400, 16'h0C21, 1'b0, 1'b0},  // R8 M[0]=0
    {13'h1803, 16'h0C21, 1'b1, 1'b0},  // R6 divide by R3=0
    {13'h000D, 16'h0C21, 1'b1, 1'b1},  // R9 field 0x00D in register mode
    {13'h0005, 16'h0C85, 1'b1, 1'b1}   // R9 R6 flags sticky, core continues
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preload(logic [2:0] idx, logic [15:0] val);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = idx; rf_wr_data = val;
    @(negedge clk);
    rf_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin imem[i] = '0; dmem[i] = '0; end
    for (int i = 0; i < 15; i++) imem[i] = VEC[i][30:18];
    dmem[5] = 16'd10;
    dmem[1023] = 16'd2;
    rf_wr_data = '0;
    for (int r = 0; r < 8; r++) preload(3'(r), 16'd0);
    preload(3'd1, 16'd3);
    preload(3'd2, 16'd7);
    preload(3'd5, 16'd100);

    @(negedge clk);
    check("R11 acc", {16'd0, acc}, 32'd0);
    check("R11 pc", {22'd0, imem_addr}, 32'd0);
    check("R11 flags", {30'd0, div0_err, illegal_err}, 32'd0);
    rf_rd_idx = 3'd5;
    #1 check("R12 observe", {16'd0, rf_rd_data}, 32'd100);

    rst_n = 1'b1;
    for (int i = 0; i < 15; i++) begin
      check("R10 pc", {22'd0, imem_addr}, i);
      @(posedge clk); @(negedge clk);
      if (VEC[i][28]) check("R8 dmem_addr", {22'd0, dmem_addr}, {22'd0, VEC[i][27:18]});
      @(posedge clk); @(negedge clk);
      check("R10 acc held", {16'd0, acc}, (i == 0) ? 32'd0 : {16'd0, VEC[i-1][17:2]});
      @(posedge clk); @(negedge clk);
      check("R1-field vector acc", {16'd0, acc}, {16'd0, VEC[i][17:2]});
      check("R6 div0_err", {31'd0, div0_err}, {31'd0, VEC[i][1]});
      check("R9 illegal_err", {31'd0, illegal_err}, {31'd0, VEC[i][0]});
    end
    check("R10 pc after run", {22'd0, imem_addr}, 32'd15);

    rst_n = 1'b0;
    @(negedge clk);
    check("R11 acc cleared", {16'd0, acc}, 32'd0);
    check("R11 pc cleared", {22'd0, imem_addr}, 32'd0);
    check("R11 flags cleared", {30'd0, div0_err, illegal_err}, 32'd0);
    check("R12 survives reset", {16'd0, rf_rd_data}, 32'd100);
    preload(3'd6, 16'hBEEF);
    rf_rd_idx = 3'd6;
    #1 check("R12 preload R6", {16'd0, rf_rd_data}, 32'hBEEF);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 R7 rerun ADD R5", {16'd0, acc}, 32'd100);
    finish_run();
  end
endmodule